// File: doc/BRIEF.md
# EOI Owed Tracker

This block watches one edge-triggered interrupt line whose requester wants to know whether an earlier edge is still unacknowledged. When a delivery takes place, the block records which destinations accepted the interrupt in a bitmap. It also keeps a count of the acknowledgements still owed. While that count is non-zero it reports the line as coalesced, and the requester can refuse a new edge on that basis. Each destination's end-of-interrupt clears that destination's bit and lowers the count.

The bitmap and the count can disagree. This happens when the router reports an accepted count that does not match the mask, or when a delivery fails. To handle it, the block can resynchronise one destination against that destination's live pending status. If an acknowledgement would push the count below zero, the block wipes its state and rebuilds it by walking every destination, one per cycle, while it raises a busy flag. The block does no routing of its own.

Only one operation takes effect per cycle. The order of precedence is clear, then the rebuild walk, then delivery, then end-of-interrupt, then resync.

Top module: `eoi_owed_tracker`

## Requirements
- R1: After reset, owedMap and pendCount are zero, and coalesced, busy and startErr are low.
- R2: A delivery is accepted when delivValid is high, pendCount is zero and the block is not busy. One cycle later owedMap equals delivMask. pendCount equals delivCount when delivOk is 1 and is 0 when delivOk is 0.
- R3: coalesced is high exactly when pendCount is non-zero.
- R4: A delivery offered while pendCount is non-zero (not busy) leaves owedMap and pendCount unchanged, and startErr is high for the following cycle only.
- R5: An end-of-interrupt from destination eoiDest clears bit eoiDest of owedMap and lowers pendCount by one, provided that bit is set and pendCount is non-zero.
- R6: An end-of-interrupt from a destination whose owedMap bit is clear changes nothing.
- R7: A resync of destination resyncDest compares destPending[resyncDest] with owedMap[resyncDest]. If pending is 1 and the bit is 0, the bit is set and pendCount rises by one. If pending is 0 and the bit is 1, the bit is cleared and pendCount falls by one. If they agree, nothing changes.
- R8: If an end-of-interrupt or a resync fall would take pendCount below zero, the next cycle shows owedMap=0, pendCount=0 and busy=1. The block then visits destinations 0 to NUM_DEST-1, one per cycle, and sets the bit and increments the count for each destination whose destPending is 1. busy drops after NUM_DEST visits.
- R9: clearReq zeroes owedMap and pendCount in the next cycle and abandons any rebuild in progress.
- R10: Precedence is clearReq, then the rebuild walk, then delivery, then end-of-interrupt, then resync. While busy, delivery, end-of-interrupt and resync requests are ignored and raise no startErr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clearReq | input | 1 | Full clear of bitmap and count |
| delivValid | input | 1 | A delivery happened this cycle |
| delivMask | input | NUM_DEST | Destinations that accepted the delivery |
| delivCount | input | CNT_W | Accepted count reported by the router |
| delivOk | input | 1 | Delivery succeeded (0 forces the count to 0) |
| eoiValid | input | 1 | End-of-interrupt event |
| eoiDest | input | DEST_W | Destination sending the end-of-interrupt |
| resyncValid | input | 1 | Resync request for one destination |
| resyncDest | input | DEST_W | Destination to resync |
| destPending | input | NUM_DEST | Live pending status of every destination |
| coalesced | output | 1 | Acknowledgements still owed |
| busy | output | 1 | Rebuild walk in progress |
| startErr | output | 1 | One-cycle flag for a delivery refused because the count was non-zero |
| pendCount | output | CNT_W | Acknowledgements owed |
| owedMap | output | NUM_DEST | Destinations that still owe an acknowledgement |

## Verification
The assertions check the following on every cycle:
- a clear empties the state and leaves the block idle;
- an accepted delivery loads the mask;
- a refused delivery freezes the state and flags startErr;
- an end-of-interrupt on a clear bit changes nothing;
- a rebuild always begins from an empty state;
- requests made while busy never raise startErr.

Only the bench scenarios can show the arithmetic that spans several operations: count tracking through resync rises and falls, the bitmap that a full rebuild leaves behind, and a clear abandoning a walk part-way through.

// File: rtl/eoi_trk_pkg.sv
package eoi_trk_pkg;
  localparam int MAX_DEST = 16;
  localparam int IDX_W    = 4;

  // Strobes from control to datapath; at most one of load/dropBit/raiseBit per cycle.
  typedef struct packed {
    logic             clrAll;
    logic             load;
    logic             dropBit;
    logic             raiseBit;
    logic [IDX_W-1:0] bitIdx;
  } trkStrobe_t;
endpackage

// File: rtl/eoi_trk_dpath.sv
module eoi_trk_dpath
  import eoi_trk_pkg::*;
#(
  parameter int NUM_DEST = 8,
  parameter int DEST_W   = 3,
  parameter int CNT_W    = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  trkStrobe_t          st,
  input  logic [NUM_DEST-1:0] delivMask,
  input  logic [CNT_W-1:0]    delivCount,
  input  logic                delivOk,
  input  logic [DEST_W-1:0]   eoiDest,
  input  logic [DEST_W-1:0]   resyncDest,
  output logic [NUM_DEST-1:0] owedMap,
  output logic [CNT_W-1:0]    pendCount,
  output logic                countZero,
  output logic                eoiBit,
  output logic                rsBit
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [DEST_W-1:0] idx;
  assign idx = st.bitIdx[DEST_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      owedMap   <= '0;
      pendCount <= '0;
    end else if (st.clrAll) begin
      owedMap   <= '0;
      pendCount <= '0;
    end else if (st.load) begin
      owedMap   <= delivMask;
      pendCount <= delivOk ? delivCount : '0;
    end else if (st.dropBit) begin
      owedMap[idx] <= 1'b0;
      pendCount    <= pendCount - 1'b1;
    end else if (st.raiseBit) begin
      owedMap[idx] <= 1'b1;
      pendCount    <= (pendCount == CNT_MAX) ? pendCount : pendCount + 1'b1;
    end
  end

  assign countZero = (pendCount == '0);
  assign eoiBit    = owedMap[eoiDest];
  assign rsBit     = owedMap[resyncDest];
endmodule

// File: rtl/eoi_trk_ctrl.sv
module eoi_trk_ctrl
  import eoi_trk_pkg::*;
#(
  parameter int NUM_DEST = 8,
  parameter int DEST_W   = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                clearReq,
  input  logic                delivValid,
  input  logic                eoiValid,
  input  logic [DEST_W-1:0]   eoiDest,
  input  logic                resyncValid,
  input  logic [DEST_W-1:0]   resyncDest,
  input  logic [NUM_DEST-1:0] destPending,
  input  logic                countZero,
  input  logic                eoiBit,
  input  logic                rsBit,
  output trkStrobe_t          st,
  output logic                busy,
  output logic                startErr
);
  localparam logic [DEST_W-1:0] LAST_IDX = DEST_W'(NUM_DEST - 1);

  logic [DEST_W-1:0] walkIdx, walkIdxNext;
  logic busyNext, errNext;

  always_comb begin
    st          = '0;
    busyNext    = busy;
    walkIdxNext = walkIdx;
    errNext     = 1'b0;
    if (clearReq) begin
      st.clrAll = 1'b1;
      busyNext  = 1'b0;
    end else if (busy) begin
      st.raiseBit = destPending[walkIdx];
      st.bitIdx   = IDX_W'(walkIdx);
      if (walkIdx == LAST_IDX) busyNext = 1'b0;
      else                     walkIdxNext = walkIdx + 1'b1;
    end else if (delivValid) begin
      if (countZero) st.load = 1'b1;
      else           errNext = 1'b1;
    end else if (eoiValid && eoiBit) begin
      if (countZero) begin
        st.clrAll   = 1'b1;
        busyNext    = 1'b1;
        walkIdxNext = '0;
      end else begin
        st.dropBit = 1'b1;
        st.bitIdx  = IDX_W'(eoiDest);
      end
    end else if (resyncValid && (rsBit != destPending[resyncDest])) begin
      st.bitIdx = IDX_W'(resyncDest);
      if (!rsBit) begin
        st.raiseBit = 1'b1;
      end else if (countZero) begin
        st.clrAll   = 1'b1;
        busyNext    = 1'b1;
        walkIdxNext = '0;
      end else begin
        st.dropBit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      walkIdx  <= '0;
      startErr <= 1'b0;
    end else begin
      busy     <= busyNext;
      walkIdx  <= walkIdxNext;
      startErr <= errNext;
    end
  end
endmodule

// File: rtl/eoi_owed_tracker.sv
module eoi_owed_tracker
  import eoi_trk_pkg::*;
#(
  parameter  int NUM_DEST = 8,
  localparam int DEST_W   = (NUM_DEST > 1) ? $clog2(NUM_DEST) : 1,
  localparam int CNT_W    = $clog2(NUM_DEST + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                clearReq,
  input  logic                delivValid,
  input  logic [NUM_DEST-1:0] delivMask,
  input  logic [CNT_W-1:0]    delivCount,
  input  logic                delivOk,
  input  logic                eoiValid,
  input  logic [DEST_W-1:0]   eoiDest,
  input  logic                resyncValid,
  input  logic [DEST_W-1:0]   resyncDest,
  input  logic [NUM_DEST-1:0] destPending,
  output logic                coalesced,
  output logic                busy,
  output logic                startErr,
  output logic [CNT_W-1:0]    pendCount,
  output logic [NUM_DEST-1:0] owedMap
);
  trkStrobe_t st;
  logic countZero, eoiBit, rsBit;

  eoi_trk_ctrl #(.NUM_DEST(NUM_DEST), .DEST_W(DEST_W)) uCtrl (
    .clk(clk), .rstN(rstN), .clearReq(clearReq), .delivValid(delivValid),
    .eoiValid(eoiValid), .eoiDest(eoiDest), .resyncValid(resyncValid),
    .resyncDest(resyncDest), .destPending(destPending), .countZero(countZero),
    .eoiBit(eoiBit), .rsBit(rsBit), .st(st), .busy(busy), .startErr(startErr)
  );

  eoi_trk_dpath #(.NUM_DEST(NUM_DEST), .DEST_W(DEST_W), .CNT_W(CNT_W)) uDpath (
    .clk(clk), .rstN(rstN), .st(st), .delivMask(delivMask),
    .delivCount(delivCount), .delivOk(delivOk), .eoiDest(eoiDest),
    .resyncDest(resyncDest), .owedMap(owedMap), .pendCount(pendCount),
    .countZero(countZero), .eoiBit(eoiBit), .rsBit(rsBit)
  );

  assign coalesced = !countZero;
endmodule

// File: rtl/eoi_owed_checker.sv
module eoi_owed_checker #(
  parameter int NUM_DEST = 8,
  parameter int DEST_W   = 3,
  parameter int CNT_W    = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                clearReq,
  input logic                delivValid,
  input logic [NUM_DEST-1:0] delivMask,
  input logic                eoiValid,
  input logic [DEST_W-1:0]   eoiDest,
  input logic                busy,
  input logic                startErr,
  input logic [CNT_W-1:0]    pendCount,
  input logic [NUM_DEST-1:0] owedMap
);
  p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rstN)
    clearReq |=> (pendCount == '0) && (owedMap == '0) && !busy);

  p_load_mask_r2: assert property (@(posedge clk) disable iff (!rstN)
    delivValid && !clearReq && !busy && (pendCount == '0) |=> owedMap == $past(delivMask));

  p_refuse_r4: assert property (@(posedge clk) disable iff (!rstN)
    delivValid && !clearReq && !busy && (pendCount != '0)
    |=> startErr && $stable(owedMap) && $stable(pendCount));

  p_eoi_noop_r6: assert property (@(posedge clk) disable iff (!rstN)
    eoiValid && !clearReq && !busy && !delivValid && !owedMap[eoiDest]
    |=> $stable(owedMap) && $stable(pendCount));

  p_walk_start_empty_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (pendCount == '0) && (owedMap == '0));

  p_busy_no_err_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy && !clearReq && delivValid |=> !startErr);
endmodule

bind eoi_owed_tracker eoi_owed_checker #(.NUM_DEST(NUM_DEST), .DEST_W(DEST_W), .CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .clearReq(clearReq), .delivValid(delivValid),
  .delivMask(delivMask), .eoiValid(eoiValid), .eoiDest(eoiDest), .busy(busy),
  .startErr(startErr), .pendCount(pendCount), .owedMap(owedMap)
);

// File: tb/tb_eoi_owed_tracker.sv
module tb_eoi_owed_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int DW = 3;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clearReq = 0, delivValid = 0, delivOk = 0, eoiValid = 0, resyncValid = 0;
  logic [N-1:0] delivMask = '0, destPending = '0;
  logic [CW-1:0] delivCount = '0;
  logic [DW-1:0] eoiDest = '0, resyncDest = '0;
  logic coalesced, busy, startErr;
  logic [CW-1:0] pendCount;
  logic [N-1:0] owedMap;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eoi_owed_tracker #(.NUM_DEST(N)) dut (
    .clk(clk), .rstN(rstN), .clearReq(clearReq), .delivValid(delivValid),
    .delivMask(delivMask), .delivCount(delivCount), .delivOk(delivOk),
    .eoiValid(eoiValid), .eoiDest(eoiDest), .resyncValid(resyncValid),
    .resyncDest(resyncDest), .destPending(destPending), .coalesced(coalesced),
    .busy(busy), .startErr(startErr), .pendCount(pendCount), .owedMap(owedMap)
  );

  // op: 0 delivery, 1 end-of-interrupt, 2 resync, 3 clear
  typedef struct packed {
    logic [1:0]    op;
    logic [N-1:0]  mask;
    logic [CW-1:0] dcnt;
    logic          ok;
    logic [DW-1:0] dest;
    logic [N-1:0]  pend;
    logic [N-1:0]  expMap;
    logic [CW-1:0] expCnt;
    logic          expErr;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 8'h0B, 4'd3, 1'b1, 3'd0, 8'h00, 8'h0B, 4'd3, 1'b0}, // R2 accepted
    '{2'd0, 8'hFF, 4'd8, 1'b1, 3'd0, 8'h00, 8'h0B, 4'd3, 1'b1}, // R4 refused
    '{2'd1, 8'h00, 4'd0, 1'b0, 3'd2, 8'h00, 8'h0B, 4'd3, 1'b0}, // R6 clear bit
    '{2'd1, 8'h00, 4'd0, 1'b0, 3'd1, 8'h00, 8'h09, 4'd2, 1'b0}, // R5
    '{2'd2, 8'h00, 4'd0, 1'b0, 3'd4, 8'h10, 8'h19, 4'd3, 1'b0}, // R7 rise
    '{2'd2, 8'h00, 4'd0, 1'b0, 3'd0, 8'h10, 8'h18, 4'd2, 1'b0}, // R7 fall
    '{2'd2, 8'h00, 4'd0, 1'b0, 3'd3, 8'h18, 8'h18, 4'd2, 1'b0}, // R7 agree
    '{2'd1, 8'h00, 4'd0, 1'b0, 3'd3, 8'h18, 8'h10, 4'd1, 1'b0}, // R5
    '{2'd1, 8'h00, 4'd0, 1'b0, 3'd4, 8'h18, 8'h00, 4'd0, 1'b0}, // R5 to zero
    '{2'd0, 8'h06, 4'd2, 1'b0, 3'd0, 8'h00, 8'h06, 4'd0, 1'b0}, // R2 failed delivery
    '{2'd0, 8'h81, 4'd2, 1'b1, 3'd0, 8'h00, 8'h81, 4'd2, 1'b0}, // R2 again
    '{2'd3, 8'h00, 4'd0, 1'b0, 3'd0, 8'h00, 8'h00, 4'd0, 1'b0}  // R9 clear
  };

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic idle();
    clearReq = 0; delivValid = 0; eoiValid = 0; resyncValid = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    idle();
  endtask

  task automatic state(input string req, input int m, input int c, input int b);
    chk(req, "owedMap", int'(owedMap), m);
    chk(req, "pendCount", int'(pendCount), c);
    chk(req, "busy", int'(busy), b);
    chk("R3", "coalesced", int'(coalesced), int'(c != 0));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 50000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    state("R1", 0, 0, 0);
    chk("R1", "startErr", int'(startErr), 0);
    rstN = 1'b1;
    tick();

    for (int i = 0; i < NV; i++) begin
      destPending = TBL[i].pend;
      case (TBL[i].op)
        2'd0: begin delivValid = 1; delivMask = TBL[i].mask; delivCount = TBL[i].dcnt; delivOk = TBL[i].ok; end
        2'd1: begin eoiValid = 1; eoiDest = TBL[i].dest; end
        2'd2: begin resyncValid = 1; resyncDest = TBL[i].dest; end
        default: clearReq = 1;
      endcase
      tick();
      state("R2/R4/R5/R6/R7 table", int'(TBL[i].expMap), int'(TBL[i].expCnt), 0);
      chk("R4", "startErr", int'(startErr), int'(TBL[i].expErr));
    end

    // R8: count zero but bit set, then EOI causes underflow and rebuild
    delivValid = 1; delivMask = 8'h05; delivCount = 0; delivOk = 1;
    tick();
    state("R2", 8'h05, 0, 0);
    destPending = 8'h24;
    eoiValid = 1; eoiDest = 3'd0;
    tick();
    state("R8 start", 0, 0, 1);
    for (int k = 1; k <= N; k++) begin
      if (k == 2) begin
        // R10: requests while busy are ignored
        delivValid = 1; delivMask = 8'hFF; delivCount = 4'd8;
        eoiValid = 1; eoiDest = 3'd2;
      end
      tick();
      if (k == 3) chk("R10", "startErr while busy", int'(startErr), 0);
      if (k == 4) chk("R8", "busy mid-walk", int'(busy), 1);
    end
    state("R8 rebuilt", 8'h24, 2, 0);

    // R9: clear abandons a rebuild
    clearReq = 1;
    tick();
    state("R9", 0, 0, 0);
    delivValid = 1; delivMask = 8'h01; delivCount = 0; delivOk = 1;
    tick();
    destPending = 8'hFF;
    eoiValid = 1; eoiDest = 3'd0;
    tick();
    chk("R8", "busy", int'(busy), 1);
    tick();
    tick();
    clearReq = 1;
    tick();
    state("R9 abort", 0, 0, 0);
    tick();
    state("R9 stays", 0, 0, 0);

    // R7 fall with zero count triggers rebuild
    delivValid = 1; delivMask = 8'h02; delivCount = 0; delivOk = 1;
    tick();
    destPending = 8'h00;
    resyncValid = 1; resyncDest = 3'd1;
    tick();
    state("R8 via resync", 0, 0, 1);
    repeat (N) tick();
    state("R8 empty rebuild", 0, 0, 0);

    // R10: clear beats delivery in the same cycle
    delivValid = 1; delivMask = 8'h03; delivCount = 2; delivOk = 1;
    tick();
    clearReq = 1; delivValid = 1; delivMask = 8'hF0; delivCount = 4;
    tick();
    state("R10 clear wins", 0, 0, 0);
    chk("R10", "startErr", int'(startErr), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule